// File: doc/BRIEF.md
# Destination Address Filter with Loadable Match Table

This block decides whether an incoming Ethernet frame should be kept, looking only at its 48-bit destination address. The address arrives one byte per cycle, most significant byte first. Three mode inputs select promiscuous acceptance of individual addresses, acceptance of every group address, and acceptance of the all-ones address. The frame is also matched against a sixteen-entry table of stored addresses, and a sixteen-bit mask enables each entry separately. One clock after the sixth byte, a registered decision comes out as an accept flag and a two-bit tag.

The table is filled by a load engine. It walks a list of descriptors in system memory through a single word-read port, and each descriptor names the entry it overwrites. After the last descriptor, the engine reads one more word and uses it as the new enable mask. The pointer step and the word spacing follow a selectable 16-bit or 32-bit memory layout.

For bring-up, a debug port returns any stored word, but only while the device-level reset flag is held. At all other times the debug port returns zero.

Top module: `dest_addr_filter`

## Requirements
- R1: With `cfg_promisc` set, a frame whose first address byte has bit 0 clear is accepted with tag 00. A frame with that bit set is not decided by this rule and falls through to the later checks.
- R2: Given that R1 did not accept the frame, with `cfg_all_mcast` set, a frame whose first byte has bit 0 set is accepted with tag 01 (multicast). This holds even when the address is all ones.
- R3: Given that R1 and R2 did not accept the frame, with `cfg_bcast_ok` set, the address FF:FF:FF:FF:FF:FF is accepted with tag 10 (broadcast). Tag 11 never appears.
- R4: Given that no earlier rule accepted the frame, it is accepted with tag 00 when some table entry has its `cam_enable` bit set and its three words equal the address. The first address byte compares with bits 15:8 of word 0, the second with bits 7:0 of word 0, and so on through word 2. Disabled entries never match.
- R5: A frame that no rule accepts is reported with `dec_accept` 0 and tag 00.
- R6: `dec_valid` is high for exactly the one cycle after the clock edge that samples the sixth valid byte. Idle cycles between bytes only delay the decision.
- R7: The load engine reads each descriptor as four words at offsets 0, 1, 2, 3, spaced 2 bytes apart (`load_wide`=0) or 4 bytes apart (`load_wide`=1). The low 4 bits of word 0 pick the entry, and words 1 to 3 become table words 0 to 2. The pointer then advances by 8 or 16 bytes. The read address is held until `mem_rd_valid`.
- R8: Only bits 4:0 of `load_count` give the number of descriptors. With those bits zero, the engine reads only the mask word.
- R9: After the descriptors, the engine reads the word at the current pointer into `cam_enable`. In the same edge, `load_busy` falls and `load_done` pulses for one cycle. `load_start` has no effect while `load_busy` is high, and `cam_enable` changes only with `load_done`.
- R10: `dbg_data` returns table word `dbg_word` (0 to 2) of entry `dbg_entry` while `dev_in_reset` is high. It returns 0 for `dbg_word`=3, and 0 whenever `dev_in_reset` is low.
- R11: After reset, the table and `cam_enable` are zero, and `dec_valid`, `load_busy`, `load_done` and `mem_rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_promisc | input | 1 | Accept individual addresses |
| cfg_all_mcast | input | 1 | Accept every group address |
| cfg_bcast_ok | input | 1 | Accept the all-ones address |
| byte_valid | input | 1 | Address byte present this cycle |
| byte_data | input | 8 | Address byte, first byte first |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_tag | output | 2 | 00 none, 01 multicast, 10 broadcast |
| load_start | input | 1 | Start a table load |
| load_base | input | 32 | Byte address of the first descriptor |
| load_count | input | 16 | Descriptor count, bits 4:0 used |
| load_wide | input | 1 | 32-bit memory layout |
| mem_rd_req | output | 1 | Word read request |
| mem_rd_addr | output | 32 | Word read byte address |
| mem_rd_valid | input | 1 | Read data strobe |
| mem_rd_data | input | 16 | Read data |
| load_busy | output | 1 | Load in progress |
| load_done | output | 1 | Load finished pulse |
| cam_enable | output | 16 | Per-entry enable mask |
| dev_in_reset | input | 1 | Device reset flag gating the debug port |
| dbg_entry | input | 4 | Debug entry index |
| dbg_word | input | 2 | Debug word select |
| dbg_data | output | 16 | Debug read data |

## Verification
The situation hardest to reach from the ports is a second `load_start` that arrives partway through a long descriptor walk, while the memory answers with a latency that keeps changing. To create it, the stimulus runs a three-descriptor load with two-cycle read latency and pulses a start with a different base two cycles in. Every read address is checked against a queue built from the descriptor list, so any restart or extra read shows up at once. The priority corners are set up deliberately by chaining mode combinations: a group address that matches a table entry while in promiscuous mode, and an all-ones address with both group and broadcast acceptance enabled.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

    parameter int unsigned ADDR_BITS = 48;

    typedef enum logic [1:0] {
        TAG_NONE  = 2'b00,
        TAG_MCAST = 2'b01,
        TAG_BCAST = 2'b10
    } frame_tag_e;

    typedef struct packed {
        logic promisc;
        logic all_mcast;
        logic bcast_ok;
    } filter_mode_t;

    typedef struct packed {
        logic       accept;
        frame_tag_e tag;
    } filter_result_t;

    typedef enum logic [2:0] {
        LD_IDLE,
        LD_INDEX,
        LD_WORD0,
        LD_WORD1,
        LD_WORD2,
        LD_MASK
    } load_state_e;

    // Group bit: bit 0 of the first byte on the wire.
    function automatic logic is_group(input logic [ADDR_BITS-1:0] a);
        return a[ADDR_BITS-8];
    endfunction

    function automatic logic is_all_ones(input logic [ADDR_BITS-1:0] a);
        return &a;
    endfunction

endpackage

// File: rtl/dmf_byte_gather.sv
module dmf_byte_gather #(
    parameter int unsigned NBYTES = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [7:0]            in_byte,
    output logic                  last,
    output logic [NBYTES*8-1:0]   addr
);
    localparam int unsigned CW = $clog2(NBYTES);
    localparam int unsigned HW = (NBYTES - 1) * 8;

    logic [CW-1:0] cnt;
    logic [HW-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            held <= '0;
        end else if (in_valid) begin
            held <= {held[HW-9:0], in_byte};
            if (cnt == CW'(NBYTES - 1)) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign last = in_valid && (cnt == CW'(NBYTES - 1));
    assign addr = {held, in_byte};

endmodule

// File: rtl/dmf_cam_store.sv
module dmf_cam_store #(
    parameter int unsigned N_ENTRY = 16,
    parameter int unsigned DW      = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [$clog2(N_ENTRY)-1:0] wr_idx,
    input  logic [1:0]                 wr_sel,
    input  logic [DW-1:0]              wr_data,
    input  logic [N_ENTRY-1:0]         en_mask,
    input  logic [3*DW-1:0]            key,
    output logic                       hit,
    input  logic                       dbg_allow,
    input  logic [$clog2(N_ENTRY)-1:0] dbg_idx,
    input  logic [1:0]                 dbg_sel,
    output logic [DW-1:0]              dbg_data
);
    localparam int unsigned IDX_W = $clog2(N_ENTRY);
    localparam int unsigned EW    = 3 * DW;

    logic [EW-1:0]      ent_arr [N_ENTRY];
    logic [N_ENTRY-1:0] match_vec;

    for (genvar g = 0; g < N_ENTRY; g++) begin : g_ent
        logic [EW-1:0] ent;
        always_ff @(posedge clk) begin
            if (rst) begin
                ent <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                case (wr_sel)
                    2'd0:    ent[EW-1:2*DW]   <= wr_data;
                    2'd1:    ent[2*DW-1:DW]   <= wr_data;
                    2'd2:    ent[DW-1:0]      <= wr_data;
                    default: ;
                endcase
            end
        end
        assign match_vec[g] = en_mask[g] && (ent == key);
        assign ent_arr[g]   = ent;
    end

    assign hit = |match_vec;

    logic [EW-1:0] dbg_ent;
    assign dbg_ent = ent_arr[dbg_idx];

    always_comb begin
        dbg_data = '0;
        if (dbg_allow) begin
            case (dbg_sel)
                2'd0:    dbg_data = dbg_ent[EW-1:2*DW];
                2'd1:    dbg_data = dbg_ent[2*DW-1:DW];
                2'd2:    dbg_data = dbg_ent[DW-1:0];
                default: dbg_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/dmf_cam_loader.sv
module dmf_cam_loader
    import dmf_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned DW    = 16,
    parameter int unsigned CNT_W = 5,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [AW-1:0]    base,
    input  logic [CNT_W-1:0] count,
    input  logic             wide,
    output logic             rd_req,
    output logic [AW-1:0]    rd_addr,
    input  logic             rd_valid,
    input  logic [DW-1:0]    rd_data,
    output logic             ent_we,
    output logic [IDX_W-1:0] ent_idx,
    output logic [1:0]       ent_sel,
    output logic [DW-1:0]    ent_data,
    output logic             mask_we,
    output logic             busy,
    output logic             done
);
    localparam int unsigned NARROW_STEP = 4 * (DW / 8);
    localparam int unsigned WIDE_STEP   = 2 * NARROW_STEP;

    load_state_e      st;
    logic [AW-1:0]    ptr;
    logic [CNT_W-1:0] left;
    logic             wide_q;
    logic [IDX_W-1:0] idx_q;
    logic [1:0]       word_no;
    logic             in_entry_word;

    always_comb begin
        case (st)
            LD_WORD0: word_no = 2'd1;
            LD_WORD1: word_no = 2'd2;
            LD_WORD2: word_no = 2'd3;
            default:  word_no = 2'd0;
        endcase
    end

    assign in_entry_word = (st == LD_WORD0) || (st == LD_WORD1) || (st == LD_WORD2);
    assign rd_req   = (st != LD_IDLE);
    assign rd_addr  = ptr + (wide_q ? AW'({word_no, 2'b00}) : AW'({word_no, 1'b0}));
    assign ent_we   = rd_valid && in_entry_word;
    assign ent_sel  = word_no - 2'd1;
    assign ent_idx  = idx_q;
    assign ent_data = rd_data;
    assign mask_we  = rd_valid && (st == LD_MASK);
    assign busy     = rd_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= LD_IDLE;
            ptr    <= '0;
            left   <= '0;
            wide_q <= 1'b0;
            idx_q  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                LD_IDLE: begin
                    if (start) begin
                        ptr    <= base;
                        left   <= count;
                        wide_q <= wide;
                        st     <= (count == '0) ? LD_MASK : LD_INDEX;
                    end
                end
                LD_INDEX: begin
                    if (rd_valid) begin
                        idx_q <= rd_data[IDX_W-1:0];
                        st    <= LD_WORD0;
                    end
                end
                LD_WORD0: if (rd_valid) st <= LD_WORD1;
                LD_WORD1: if (rd_valid) st <= LD_WORD2;
                LD_WORD2: begin
                    if (rd_valid) begin
                        left <= left - CNT_W'(1);
                        ptr  <= ptr + (wide_q ? AW'(WIDE_STEP) : AW'(NARROW_STEP));
                        st   <= (left == CNT_W'(1)) ? LD_MASK : LD_INDEX;
                    end
                end
                LD_MASK: begin
                    if (rd_valid) begin
                        st   <= LD_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st <= LD_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
    import dmf_pkg::*;
#(
    parameter int unsigned AW           = 32,
    parameter int unsigned DW           = 16,
    parameter int unsigned N_ENTRY      = 16,
    parameter int unsigned CNT_W        = 5,
    parameter int unsigned COUNT_PORT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_promisc,
    input  logic                       cfg_all_mcast,
    input  logic                       cfg_bcast_ok,
    input  logic                       byte_valid,
    input  logic [7:0]                 byte_data,
    output logic                       dec_valid,
    output logic                       dec_accept,
    output logic [1:0]                 dec_tag,
    input  logic                       load_start,
    input  logic [AW-1:0]              load_base,
    input  logic [COUNT_PORT_W-1:0]    load_count,
    input  logic                       load_wide,
    output logic                       mem_rd_req,
    output logic [AW-1:0]              mem_rd_addr,
    input  logic                       mem_rd_valid,
    input  logic [DW-1:0]              mem_rd_data,
    output logic                       load_busy,
    output logic                       load_done,
    output logic [N_ENTRY-1:0]         cam_enable,
    input  logic                       dev_in_reset,
    input  logic [$clog2(N_ENTRY)-1:0] dbg_entry,
    input  logic [1:0]                 dbg_word,
    output logic [DW-1:0]              dbg_data
);
    localparam int unsigned IDX_W  = $clog2(N_ENTRY);
    localparam int unsigned NBYTES = ADDR_BITS / 8;

    filter_mode_t           mode;
    filter_result_t         res_d, res_q;
    logic                   addr_last;
    logic [ADDR_BITS-1:0]   addr_now;
    logic                   cam_hit;
    logic                   ent_we, mask_we;
    logic [IDX_W-1:0]       ent_idx;
    logic [1:0]             ent_sel;
    logic [DW-1:0]          ent_data;
    logic                   unused_count_hi;

    assign unused_count_hi = ^load_count[COUNT_PORT_W-1:CNT_W];
    assign mode = '{promisc: cfg_promisc, all_mcast: cfg_all_mcast, bcast_ok: cfg_bcast_ok};

    dmf_byte_gather #(.NBYTES(NBYTES)) u_gather (
        .clk      (clk),
        .rst      (rst),
        .in_valid (byte_valid),
        .in_byte  (byte_data),
        .last     (addr_last),
        .addr     (addr_now)
    );

    dmf_cam_store #(.N_ENTRY(N_ENTRY), .DW(DW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (ent_we),
        .wr_idx    (ent_idx),
        .wr_sel    (ent_sel),
        .wr_data   (ent_data),
        .en_mask   (cam_enable),
        .key       (addr_now),
        .hit       (cam_hit),
        .dbg_allow (dev_in_reset),
        .dbg_idx   (dbg_entry),
        .dbg_sel   (dbg_word),
        .dbg_data  (dbg_data)
    );

    dmf_cam_loader #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_loader (
        .clk      (clk),
        .rst      (rst),
        .start    (load_start),
        .base     (load_base),
        .count    (load_count[CNT_W-1:0]),
        .wide     (load_wide),
        .rd_req   (mem_rd_req),
        .rd_addr  (mem_rd_addr),
        .rd_valid (mem_rd_valid),
        .rd_data  (mem_rd_data),
        .ent_we   (ent_we),
        .ent_idx  (ent_idx),
        .ent_sel  (ent_sel),
        .ent_data (ent_data),
        .mask_we  (mask_we),
        .busy     (load_busy),
        .done     (load_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cam_enable <= '0;
        end else if (mask_we) begin
            cam_enable <= mem_rd_data[N_ENTRY-1:0];
        end
    end

    // Fixed priority: individual-promiscuous, all-group, all-ones, table.
    always_comb begin
        res_d = '{accept: 1'b0, tag: TAG_NONE};
        if (mode.promisc && !is_group(addr_now)) begin
            res_d.accept = 1'b1;
        end else if (mode.all_mcast && is_group(addr_now)) begin
            res_d = '{accept: 1'b1, tag: TAG_MCAST};
        end else if (mode.bcast_ok && is_all_ones(addr_now)) begin
            res_d = '{accept: 1'b1, tag: TAG_BCAST};
        end else if (cam_hit) begin
            res_d.accept = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid <= 1'b0;
            res_q     <= '{accept: 1'b0, tag: TAG_NONE};
        end else begin
            dec_valid <= addr_last;
            if (addr_last) begin
                res_q <= res_d;
            end
        end
    end

    assign dec_accept = res_q.accept;
    assign dec_tag    = res_q.tag;

endmodule

// File: rtl/dest_addr_filter_chk.sv
module dest_addr_filter_chk #(
    parameter int unsigned AW      = 32,
    parameter int unsigned DW      = 16,
    parameter int unsigned N_ENTRY = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               dec_valid,
    input logic               dec_accept,
    input logic [1:0]         dec_tag,
    input logic               mem_rd_req,
    input logic [AW-1:0]      mem_rd_addr,
    input logic               mem_rd_valid,
    input logic               load_busy,
    input logic               load_done,
    input logic [N_ENTRY-1:0] cam_enable,
    input logic               dev_in_reset,
    input logic [DW-1:0]      dbg_data
);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);

    a_r5_reject_untagged: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_accept) |-> (dec_tag == 2'b00));

    a_r3_tag_legal: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (dec_tag != 2'b11));

    a_r7_req_needs_busy: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> load_busy);

    a_r7_hold_addr: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        load_done |-> (!load_busy && $past(load_busy)));

    a_r9_mask_only_on_done: assert property (@(posedge clk) disable iff (rst)
        !load_done |-> $stable(cam_enable));

    a_r10_dbg_dark: assert property (@(posedge clk) disable iff (rst)
        !dev_in_reset |-> (dbg_data == '0));

endmodule

bind dest_addr_filter dest_addr_filter_chk #(.AW(AW), .DW(DW), .N_ENTRY(N_ENTRY)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .dec_valid    (dec_valid),
    .dec_accept   (dec_accept),
    .dec_tag      (dec_tag),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .load_busy    (load_busy),
    .load_done    (load_done),
    .cam_enable   (cam_enable),
    .dev_in_reset (dev_in_reset),
    .dbg_data     (dbg_data)
);

// File: tb/dest_addr_filter_test.sv
`timescale 1ns/1ps
module dest_addr_filter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_promisc = 1'b0, cfg_all_mcast = 1'b0, cfg_bcast_ok = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        dec_valid, dec_accept;
    logic [1:0]  dec_tag;
    logic        load_start = 1'b0;
    logic [31:0] load_base = '0;
    logic [15:0] load_count = '0;
    logic        load_wide = 1'b0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [15:0] mem_rd_data = '0;
    logic        load_busy, load_done;
    logic [15:0] cam_enable;
    logic        dev_in_reset = 1'b0;
    logic [3:0]  dbg_entry = '0;
    logic [1:0]  dbg_word = '0;
    logic [15:0] dbg_data;

    always #2 clk = ~clk;

    dest_addr_filter uut (
        .clk(clk), .rst(rst),
        .cfg_promisc(cfg_promisc), .cfg_all_mcast(cfg_all_mcast), .cfg_bcast_ok(cfg_bcast_ok),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_tag(dec_tag),
        .load_start(load_start), .load_base(load_base), .load_count(load_count), .load_wide(load_wide),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .load_busy(load_busy), .load_done(load_done), .cam_enable(cam_enable),
        .dev_in_reset(dev_in_reset), .dbg_entry(dbg_entry), .dbg_word(dbg_word), .dbg_data(dbg_data)
    );

    int n_checks = 0;
    int n_err    = 0;

    logic [15:0] mem [int unsigned];
    int unsigned exp_q [$];
    logic [47:0] m_tab [16];
    logic [47:0] p_tab [16];
    logic [15:0] m_en = '0;
    logic [15:0] p_en = '0;
    bit          seen_done = 0;
    int          lat_set = 1;
    int          lat_cnt = 0;

    int          m_cnt = 0;
    logic [47:0] m_addr = '0;
    bit          exp_v = 0;
    bit          exp_acc = 0;
    logic [1:0]  exp_tag = 2'b00;
    string       exp_rule = "R5";

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural rule evaluation, priority R1 > R2 > R3 > R4, else R5.
    function automatic void ref_decide(input logic [47:0] a);
        exp_acc  = 0;
        exp_tag  = 2'b00;
        exp_rule = "R5";
        if (cfg_promisc && !a[40]) begin
            exp_acc = 1; exp_rule = "R1";
        end else if (cfg_all_mcast && a[40]) begin
            exp_acc = 1; exp_tag = 2'b01; exp_rule = "R2";
        end else if (cfg_bcast_ok && a == 48'hFFFF_FFFF_FFFF) begin
            exp_acc = 1; exp_tag = 2'b10; exp_rule = "R3";
        end else begin
            for (int i = 0; i < 16; i++) begin
                if (m_en[i] && m_tab[i] == a) begin
                    exp_acc = 1; exp_rule = "R4";
                end
            end
        end
    endfunction

    // Per-clock monitor
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0;
            exp_v = 0;
            for (int i = 0; i < 16; i++) m_tab[i] = '0;
            m_en = '0;
        end else begin
            exp_v = 0;
            if (byte_valid) begin
                m_addr = {m_addr[39:0], byte_data};
                if (m_cnt == 5) begin
                    m_cnt = 0;
                    exp_v = 1;
                    ref_decide(m_addr);
                end else begin
                    m_cnt++;
                end
            end
        end
        #1;
        if (!rst) begin
            check(dec_valid === exp_v, "R6", "dec_valid", dec_valid, exp_v);
            if (exp_v) begin
                check(dec_accept === exp_acc, exp_rule, "accept", dec_accept, exp_acc);
                check(dec_tag === exp_tag, exp_rule, "tag", dec_tag, exp_tag);
            end
            if (load_done === 1'b1) begin
                seen_done = 1;
                m_tab = p_tab;
                m_en  = p_en;
            end
        end
    end

    // Memory model with variable latency; verifies each read address (R7)
    always @(negedge clk) begin
        mem_rd_valid = 1'b0;
        if (!rst && mem_rd_req === 1'b1) begin
            lat_cnt++;
            if (lat_cnt >= lat_set) begin
                lat_cnt = 0;
                mem_rd_valid = 1'b1;
                mem_rd_data = mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 16'h0000;
                if (exp_q.size() == 0) begin
                    check(0, "R7", "unexpected read addr", mem_rd_addr, 0);
                end else begin
                    check(mem_rd_addr == exp_q[0], "R7", "read addr", mem_rd_addr, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
        end else begin
            lat_cnt = 0;
        end
    end

    task automatic plan_load(input int unsigned base, input int unsigned cnt, input bit wide);
        int unsigned ptr;
        int unsigned s;
        int          n;
        logic [3:0]  idx;
        ptr = base;
        s   = wide ? 4 : 2;
        n   = int'(cnt & 31);   // R8: only five count bits
        p_tab = m_tab;
        exp_q.delete();
        for (int k = 0; k < n; k++) begin
            for (int w = 0; w < 4; w++) exp_q.push_back(ptr + w * s);
            idx = mem[ptr][3:0];
            p_tab[idx] = {mem[ptr + s], mem[ptr + 2 * s], mem[ptr + 3 * s]};
            ptr += wide ? 16 : 8;
        end
        exp_q.push_back(ptr);
        p_en = mem[ptr];
    endtask

    task automatic do_load(input int unsigned base, input int unsigned cnt, input bit wide, input bit poke);
        plan_load(base, cnt, wide);
        seen_done = 0;
        @(negedge clk);
        load_base = base; load_count = 16'(cnt); load_wide = wide; load_start = 1'b1;
        @(negedge clk);
        load_start = 1'b0;
        check(load_busy === 1'b1, "R9", "busy after start", load_busy, 1);
        if (poke) begin
            // R9: start during busy must not restart the walk
            @(negedge clk);
            load_base = 32'h700; load_count = 16'h0003; load_start = 1'b1;
            @(negedge clk);
            load_start = 1'b0;
        end
        for (int t = 0; t < 400 && !seen_done; t++) @(negedge clk);
        check(seen_done, "R9", "load_done seen", seen_done, 1);
        check(exp_q.size() == 0, "R7", "reads left over", exp_q.size(), 0);
        check(load_busy === 1'b0, "R9", "busy after done", load_busy, 0);
        check(cam_enable === p_en, "R8", "enable mask", cam_enable, p_en);
    endtask

    task automatic send_frame(input logic [47:0] a, input bit bubble);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_data  = a[47 - 8 * i -: 8];
            if (bubble && i == 2) begin
                @(negedge clk);
                byte_valid = 1'b0;
            end
        end
        @(negedge clk);
        byte_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_mode(input bit p, input bit m, input bit b);
        @(negedge clk);
        cfg_promisc = p; cfg_all_mcast = m; cfg_bcast_ok = b;
    endtask

    task automatic check_dbg(input int e);
        logic [15:0] expw;
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            dev_in_reset = 1'b1; dbg_entry = 4'(e); dbg_word = 2'(w);
            #1;
            case (w)
                0: expw = m_tab[e][47:32];
                1: expw = m_tab[e][31:16];
                2: expw = m_tab[e][15:0];
                default: expw = 16'h0000;
            endcase
            check(dbg_data === expw, "R10", "debug word", dbg_data, expw);
        end
        @(negedge clk);
        dev_in_reset = 1'b0; dbg_word = 2'd0;
        #1;
        check(dbg_data === 16'h0000, "R10", "debug outside reset", dbg_data, 0);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL R6 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // narrow-layout list at 0x100: entries 2, 5, 15; mask enables 2 and 15
        mem[32'h100] = 16'hFFE2; mem[32'h102] = 16'h0211; mem[32'h104] = 16'h2233; mem[32'h106] = 16'h4455;
        mem[32'h108] = 16'h0005; mem[32'h10A] = 16'h0A0B; mem[32'h10C] = 16'h0C0D; mem[32'h10E] = 16'h0E0F;
        mem[32'h110] = 16'h000F; mem[32'h112] = 16'h0100; mem[32'h114] = 16'h5E00; mem[32'h116] = 16'h00FB;
        mem[32'h118] = 16'h8004;
        // wide-layout list at 0x400: entry 3, mask adds it
        mem[32'h400] = 16'hFFF3; mem[32'h404] = 16'hAABB; mem[32'h408] = 16'hCCDD; mem[32'h40C] = 16'hEEF0;
        mem[32'h410] = 16'h800C;
        // mask-only load at 0x500
        mem[32'h500] = 16'h0008;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(dec_valid === 1'b0, "R11", "dec_valid after reset", dec_valid, 0);
        check(load_busy === 1'b0, "R11", "busy after reset", load_busy, 0);
        check(load_done === 1'b0, "R11", "done after reset", load_done, 0);
        check(mem_rd_req === 1'b0, "R11", "read req after reset", mem_rd_req, 0);
        check(cam_enable === 16'h0000, "R11", "mask after reset", cam_enable, 0);
        check_dbg(2);

        lat_set = 2;
        do_load(32'h100, 3, 1'b0, 1'b1);
        check_dbg(2);
        check_dbg(15);

        // R4 / R5 with all modes off
        send_frame(48'h0211_2233_4455, 0);
        send_frame(48'h0A0B_0C0D_0E0F, 0);   // disabled entry
        send_frame(48'h0100_5E00_00FB, 1);   // R6 byte bubble
        send_frame(48'h0211_2233_4456, 0);
        // R1
        set_mode(1, 0, 0);
        send_frame(48'h5A12_3456_7890, 0);
        send_frame(48'hFFFF_FFFF_FFFF, 0);
        send_frame(48'h0100_5E00_00FB, 0);   // group falls through to table
        send_frame(48'h0300_0000_AAAA, 0);
        // R2
        set_mode(0, 1, 0);
        send_frame(48'h0300_0000_AAAA, 0);
        send_frame(48'h0211_2233_4455, 0);
        send_frame(48'h5A12_3456_7890, 0);
        set_mode(0, 1, 1);
        send_frame(48'hFFFF_FFFF_FFFF, 0);   // group rule outranks all-ones
        // R3
        set_mode(0, 0, 1);
        send_frame(48'hFFFF_FFFF_FFFF, 0);
        send_frame(48'h0300_0000_AAAA, 0);
        send_frame(48'hFFFF_FFFF_FFFE, 0);
        set_mode(0, 0, 0);

        lat_set = 3;
        do_load(32'h400, 32'h21, 1'b1, 1'b0);  // R8: count upper bits ignored
        check_dbg(3);
        send_frame(48'hAABB_CCDD_EEF0, 0);

        lat_set = 1;
        do_load(32'h500, 32'h20, 1'b0, 1'b0);  // R8: zero count, mask only
        send_frame(48'hAABB_CCDD_EEF0, 0);
        send_frame(48'h0211_2233_4455, 0);
        send_frame(48'h0100_5E00_00FB, 0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule